// File: doc/BRIEF.md
# Parallel NOR Flash Identification Sequencer

This block sits on the host side of a simple synchronous memory bus and works out which parallel NOR flash device is attached. The host pulses `start` with a base address, a device width code, an interleave count, the bus width in bytes and the size of the mapped window. The sequencer then runs a probe attempt on its own. It returns the device to read mode, sends the unlock and identify-mode commands, and reads back a manufacturer code and a device code. It then looks the pair up in a small identification table that is set through parameters.

If the pair is not in the table, the sequencer tries again with a different set of unlock addresses. The second attempt ORs each unlock address with a copy of itself shifted left by four bits. The third attempt uses no unlock cycles at all. Only after all three attempts miss does it report failure. Before each attempt it checks the addresses it is about to write against the map size. When a lookup hits, the device is put back into read mode. The outcome (done, found, table index, the two codes and an error code) stays on the outputs until the next probe starts.

Top module: `flash_id_probe`

## Requirements
- R1: While reset is held and after it is released, `done`, `found` and `bus_req` are 0 and `err_code` is 0. A `start` pulse while idle clears `done` and begins a probe.
- R2: Every probe attempt opens with two writes to the base address: 0xF0 first, then 0xFF.
- R3: `width_code` selects the unlock address pair for the first attempt. Code 0 (x8) gives 0x555 and 0x2AA. Code 1 (x16) gives 0xAAA, and then 0x555 when `bus_bytes` equals `interleave`, otherwise 0x554. Code 2 (x32) gives 0x1555 and 0xAAA.
- R4: After the read-mode writes, an attempt writes 0xAA to base+unlock1, then 0x55 to base+unlock2, then 0x90 to base+unlock1. When unlock1 is zero, the 0xAA and 0x55 writes are left out.
- R5: An attempt then reads the manufacturer code at the base address and the device code at base + `interleave` × (1 << `width_code`) bytes. Each value is ANDed with a mask as wide as the device: 8, 16 or 32 bits.
- R6: A lookup compares the masked pair with every table entry. When several entries match, the lowest index wins. It reports `found`=1, `err_code`=0, `table_index` and both codes.
- R7: After the first miss, each unlock address becomes itself ORed with itself shifted left by 4, and a new attempt is made. After the second miss, both unlock addresses become zero and a final attempt is made. After the third miss, the probe ends with `err_code`=2 and sends no further writes.
- R8: Before each attempt, if base, base+unlock1 or base+unlock2 is greater than or equal to `map_size`, the probe ends with `err_code`=1 and that attempt makes no bus access.
- R9: After a hit, the sequencer writes 0xF0 and then 0xFF to the base address, and only then raises `done`.
- R10: Width code 3 ends the probe on the clock after `start` with `err_code`=3 and makes no bus access.
- R11: Only one bus operation is in flight at a time. The request, address, write flag and write data stay stable until `bus_ready` is seen. Read data is taken one cycle after the cycle in which `bus_ready` accepted the read.
- R12: The results stay unchanged until the next `start`. A `start` pulse that arrives while a probe is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a probe when idle |
| base_addr | input | ADDR_W | Byte address of the device |
| width_code | input | 2 | 0 = x8, 1 = x16, 2 = x32, 3 = unsupported |
| interleave | input | 4 | Number of devices side by side on the bus |
| bus_bytes | input | 4 | Bus width in bytes |
| map_size | input | ADDR_W | Size of the mapped window in bytes |
| bus_req | output | 1 | Bus operation request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Operation address |
| bus_wdata | output | DATA_W | Write data |
| bus_ready | input | 1 | Operation accepted this cycle |
| bus_rdata | input | DATA_W | Read data, valid one cycle after acceptance |
| done | output | 1 | Probe finished |
| found | output | 1 | A table entry matched |
| table_index | output | IDX_W | Matching entry |
| mfr_code | output | DATA_W | Last masked manufacturer code |
| dev_code | output | DATA_W | Last masked device code |
| err_code | output | 2 | 0 = none, 1 = out of range, 2 = no match, 3 = bad width |

## Verification
The bench sweeps every supported width and both x16 bus/interleave relations against an attached device model. The model answers identification reads only after the unlock scheme it has been told to accept. Setting it to accept the first, second, third or no scheme shows whether the escalation order and the final failure are correct. Running each case once with a bus that is always ready and once with stalls shows whether requests are held and read data is taken at the right time. Separate runs cover upper bits that must be masked away, a code pair present twice in the table, an address window that fits the first attempt but not the second, the unsupported width, and a start pulse sent in the middle of a probe.

// File: rtl/flash_id_probe.sv
module flash_id_probe #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_IDS = 4,
  parameter logic [NUM_IDS*DATA_W-1:0] TABLE_MFR = {32'h91, 32'h37, 32'h5C, 32'h37},
  parameter logic [NUM_IDS*DATA_W-1:0] TABLE_DEV = {32'h44, 32'h2A61, 32'hB3, 32'h2A61},
  localparam int IDX_W  = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [1:0]        width_code,
  input  logic [3:0]        interleave,
  input  logic [3:0]        bus_bytes,
  input  logic [ADDR_W-1:0] map_size,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              done,
  output logic              found,
  output logic [IDX_W-1:0]  table_index,
  output logic [DATA_W-1:0] mfr_code,
  output logic [DATA_W-1:0] dev_code,
  output logic [1:0]        err_code
);

  localparam logic [1:0] E_NONE = 2'd0, E_RANGE = 2'd1, E_MISS = 2'd2, E_WIDTH = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_BUS, S_RDW, S_MATCH} st_t;

  st_t               st;
  logic [3:0]        step;
  logic [1:0]        pass;
  logic [ADDR_W-1:0] base_q, map_q, u1_q, u2_q;
  logic [1:0]        wc_q;
  logic [3:0]        ilv_q;
  logic [DATA_W-1:0] mfr_q, dev_q;
  logic              done_q, found_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        err_q;

  logic [ADDR_W-1:0] u1_init, u2_init;
  logic              bad_w;

  always_comb begin
    u1_init = '0;
    u2_init = '0;
    bad_w   = 1'b0;
    case (width_code)
      2'd0: begin u1_init = ADDR_W'('h555);  u2_init = ADDR_W'('h2AA); end
      2'd1: begin
        u1_init = ADDR_W'('hAAA);
        u2_init = (bus_bytes == interleave) ? ADDR_W'('h555) : ADDR_W'('h554);
      end
      2'd2: begin u1_init = ADDR_W'('h1555); u2_init = ADDR_W'('hAAA); end
      default: bad_w = 1'b1;
    endcase
  end

  wire [ADDR_W:0] end1 = {1'b0, base_q} + {1'b0, u1_q};
  wire [ADDR_W:0] end2 = {1'b0, base_q} + {1'b0, u2_q};
  wire out_of_range = (base_q >= map_q) || (end1 >= {1'b0, map_q}) || (end2 >= {1'b0, map_q});

  wire [ADDR_W-1:0] id_off = ADDR_W'(ilv_q) << wc_q;
  wire [DATA_W-1:0] mask = (wc_q == 2'd0) ? DATA_W'(8'hFF) :
                           (wc_q == 2'd1) ? DATA_W'(16'hFFFF) : {DATA_W{1'b1}};

  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;
  logic              op_we;

  always_comb begin
    op_addr = base_q;
    op_data = 8'h00;
    op_we   = 1'b1;
    case (step)
      4'd0, 4'd7: op_data = 8'hF0;
      4'd1, 4'd8: op_data = 8'hFF;
      4'd2: begin op_addr = base_q + u1_q; op_data = 8'hAA; end
      4'd3: begin op_addr = base_q + u2_q; op_data = 8'h55; end
      4'd4: begin op_addr = base_q + u1_q; op_data = 8'h90; end
      4'd5: op_we = 1'b0;
      4'd6: begin op_addr = base_q + id_off; op_we = 1'b0; end
      default: ;
    endcase
  end

  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (mfr_q == TABLE_MFR[i*DATA_W +: DATA_W] && dev_q == TABLE_DEV[i*DATA_W +: DATA_W]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      step    <= '0;
      pass    <= '0;
      base_q  <= '0;
      map_q   <= '0;
      u1_q    <= '0;
      u2_q    <= '0;
      wc_q    <= '0;
      ilv_q   <= '0;
      mfr_q   <= '0;
      dev_q   <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      idx_q   <= '0;
      err_q   <= E_NONE;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base_q  <= base_addr;
          map_q   <= map_size;
          wc_q    <= width_code;
          ilv_q   <= interleave;
          u1_q    <= u1_init;
          u2_q    <= u2_init;
          pass    <= '0;
          mfr_q   <= '0;
          dev_q   <= '0;
          found_q <= 1'b0;
          idx_q   <= '0;
          if (bad_w) begin
            err_q  <= E_WIDTH;
            done_q <= 1'b1;
          end else begin
            err_q  <= E_NONE;
            done_q <= 1'b0;
            st     <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (out_of_range) begin
            err_q  <= E_RANGE;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            step <= 4'd0;
            st   <= S_BUS;
          end
        end
        S_BUS: if (bus_ready) begin
          if (!op_we) st <= S_RDW;
          else if (step == 4'd1) step <= (u1_q == '0) ? 4'd4 : 4'd2;
          else if (step == 4'd8) begin
            found_q <= 1'b1;
            done_q  <= 1'b1;
            st      <= S_IDLE;
          end else step <= step + 4'd1;
        end
        S_RDW: begin
          if (step == 4'd5) begin
            mfr_q <= bus_rdata & mask;
            step  <= 4'd6;
            st    <= S_BUS;
          end else begin
            dev_q <= bus_rdata & mask;
            st    <= S_MATCH;
          end
        end
        S_MATCH: begin
          if (hit) begin
            idx_q <= hit_idx;
            step  <= 4'd7;
            st    <= S_BUS;
          end else if (pass == 2'd0) begin
            u1_q <= u1_q | (u1_q << 4);
            u2_q <= u2_q | (u2_q << 4);
            pass <= 2'd1;
            st   <= S_CHECK;
          end else if (pass == 2'd1) begin
            u1_q <= '0;
            u2_q <= '0;
            pass <= 2'd2;
            st   <= S_CHECK;
          end else begin
            err_q  <= E_MISS;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_req     = (st == S_BUS);
  assign bus_we      = op_we;
  assign bus_addr    = op_addr;
  assign bus_wdata   = op_we ? DATA_W'(op_data) : '0;
  assign done        = done_q;
  assign found       = found_q;
  assign table_index = idx_q;
  assign mfr_code    = mfr_q;
  assign dev_code    = dev_q;
  assign err_code    = err_q;

endmodule

module flash_id_probe_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] map_size,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ready,
  input logic              done,
  input logic              found,
  input logic [IDX_W-1:0]  table_index,
  input logic [DATA_W-1:0] mfr_code,
  input logic [DATA_W-1:0] dev_code,
  input logic [1:0]        err_code
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R11
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(found) && $stable(err_code) && $stable(table_index)
                        && $stable(mfr_code) && $stable(dev_code));

  // R6
  found_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> done && err_code == 2'd0);

  // R4
  cmd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> bus_wdata == DATA_W'(8'hF0) || bus_wdata == DATA_W'(8'hFF) ||
                          bus_wdata == DATA_W'(8'hAA) || bus_wdata == DATA_W'(8'h55) ||
                          bus_wdata == DATA_W'(8'h90));

  // R8
  write_in_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> bus_addr < map_size);

  // R10
  width_fast_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && err_code == 2'd3 |-> $past(start));

endmodule

bind flash_id_probe flash_id_probe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/flash_id_probe_bench.sv
module flash_id_probe_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [1:0]  width_code = '0;
  logic [3:0]  interleave = 4'd1;
  logic [3:0]  bus_bytes = 4'd1;
  logic [31:0] map_size = '0;
  logic        bus_req, bus_we, bus_ready;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        done, found;
  logic [1:0]  table_index, err_code;
  logic [31:0] mfr_code, dev_code;

  always #5 clk = ~clk;

  flash_id_probe u_flash_id_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .width_code(width_code), .interleave(interleave), .bus_bytes(bus_bytes),
    .map_size(map_size), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .done(done), .found(found), .table_index(table_index), .mfr_code(mfr_code),
    .dev_code(dev_code), .err_code(err_code));

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // device model
  int          acc = 0;
  logic [31:0] m_code = '0, d_code = '0, acc_u1 = '0;
  bit          id_mode = 0;
  bit          stall = 0;
  int          rcnt = 0;
  logic [40:0] log_q [0:63];
  int          nlog = 0;
  logic [40:0] exp_q [0:63];
  int          nexp = 0;

  function automatic logic [31:0] wmask(input logic [1:0] wc);
    return (wc == 2'd0) ? 32'hFF : (wc == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [63:0] unl(input logic [1:0] wc, input logic [3:0] il,
                                      input logic [3:0] bb, input int p);
    logic [31:0] a, b;
    a = (wc == 0) ? 32'h555 : (wc == 1) ? 32'hAAA : 32'h1555;
    b = (wc == 0) ? 32'h2AA : (wc == 1) ? ((bb == il) ? 32'h555 : 32'h554) : 32'hAAA;
    if (p >= 1) begin a = a | (a << 4); b = b | (b << 4); end
    if (p >= 2) begin a = 0; b = 0; end
    return {a, b};
  endfunction

  always @(negedge clk) begin
    rcnt++;
    bus_ready <= stall ? (rcnt % 3 != 0) : 1'b1;
  end

  always @(posedge clk) begin
    if (bus_req && bus_ready) begin
      if (nlog < 64) log_q[nlog] = {bus_we, bus_addr, bus_wdata[7:0]};
      nlog++;
      if (bus_we) begin
        if (bus_wdata[7:0] == 8'hF0 || bus_wdata[7:0] == 8'hFF) id_mode = 0;
        if (bus_wdata[7:0] == 8'h90 && acc < 3 && bus_addr == base_addr + acc_u1) id_mode = 1;
      end else begin
        logic [31:0] junk;
        junk = 32'hC3A5_7700 & ~wmask(width_code);
        if (!id_mode) bus_rdata <= 32'h0;
        else if (bus_addr == base_addr) bus_rdata <= m_code | junk;
        else if (bus_addr == base_addr + ({28'd0, interleave} << width_code)) bus_rdata <= d_code | junk;
        else bus_rdata <= 32'h0;
      end
    end
  end

  task automatic push(input bit we, input logic [31:0] a, input logic [7:0] d);
    exp_q[nexp] = {we, a, d};
    nexp++;
  endtask

  // builds expected bus trace; returns expected err and found
  task automatic build(input bit in_table, output logic [1:0] e_err, output bit e_found);
    logic [63:0] u;
    e_err = 2'd2;
    e_found = 0;
    nexp = 0;
    for (int p = 0; p < 3; p++) begin
      u = unl(width_code, interleave, bus_bytes, p);
      if (base_addr >= map_size || {1'b0, base_addr} + {1'b0, u[63:32]} >= {1'b0, map_size}
          || {1'b0, base_addr} + {1'b0, u[31:0]} >= {1'b0, map_size}) begin
        e_err = 2'd1;
        return;
      end
      push(1, base_addr, 8'hF0);
      push(1, base_addr, 8'hFF);
      if (u[63:32] != 0) begin
        push(1, base_addr + u[63:32], 8'hAA);
        push(1, base_addr + u[31:0], 8'h55);
      end
      push(1, base_addr + u[63:32], 8'h90);
      push(0, base_addr, 8'h00);
      push(0, base_addr + ({28'd0, interleave} << width_code), 8'h00);
      if (p == acc && in_table) begin
        push(1, base_addr, 8'hF0);
        push(1, base_addr, 8'hFF);
        e_err = 2'd0;
        e_found = 1;
        return;
      end
    end
  endtask

  task automatic run_probe(input string tag, input bit in_table, input logic [1:0] e_idx,
                           input bit dbl_start);
    logic [1:0] e_err;
    bit e_found;
    int first_bad;
    acc_u1 = (acc < 3) ? unl(width_code, interleave, bus_bytes, acc) >> 32 : 0;
    id_mode = 0;
    build(in_table, e_err, e_found);
    @(negedge clk);
    nlog = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    if (dbl_start) begin
      // R12: start while busy must be ignored
      repeat (3) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    chk({tag, " R7/R8 err_code"}, 64'(err_code), 64'(e_err));
    chk({tag, " R6 found"}, 64'(found), 64'(e_found));
    if (e_found) begin
      chk({tag, " R6 table_index"}, 64'(table_index), 64'(e_idx));
      chk({tag, " R5 mfr_code"}, 64'(mfr_code), 64'(m_code & wmask(width_code)));
      chk({tag, " R5 dev_code"}, 64'(dev_code), 64'(d_code & wmask(width_code)));
    end
    chk({tag, " R11 op count"}, 64'(nlog), 64'(nexp));
    first_bad = -1;
    for (int k = 0; k < nexp && k < nlog; k++)
      if (first_bad < 0 && log_q[k] !== exp_q[k]) first_bad = k;
    // R2 R3 R4 R9 trace order
    if (first_bad >= 0) chk({tag, " R2/R3/R4/R9 trace"}, 64'(log_q[first_bad]), 64'(exp_q[first_bad]));
    else chk({tag, " R2/R3/R4/R9 trace"}, 64'(0), 64'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bus_rdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done in reset", 64'(done), 0);
    chk("R1 bus_req in reset", 64'(bus_req), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 found after reset", 64'(found), 0);
    chk("R1 err after reset", 64'(err_code), 0);
    chk("R1 bus idle after reset", 64'(bus_req), 0);

    // sweep: configs x accepted scheme x bus stalls
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int a = 0; a < 4; a++) begin
        for (int s = 0; s < 2; s++) begin
          logic [1:0] ei;
          stall = (s == 1);
          acc = a;
          base_addr = 32'h4_0000;
          map_size = 32'h10_0000;
          case (cfg)
            0: begin width_code = 0; interleave = 1; bus_bytes = 1; m_code = 32'h5C; d_code = 32'hB3; ei = 1; end
            1: begin width_code = 1; interleave = 2; bus_bytes = 2; m_code = 32'h37; d_code = 32'h2A61; ei = 0; end
            2: begin width_code = 1; interleave = 2; bus_bytes = 4; m_code = 32'h37; d_code = 32'h2A61; ei = 0; end
            default: begin width_code = 2; interleave = 1; bus_bytes = 4; m_code = 32'h91; d_code = 32'h44; ei = 3; end
          endcase
          run_probe($sformatf("sweep cfg%0d acc%0d st%0d R3", cfg, a, s), 1, ei, 0);
          // R12: results hold while idle
          repeat (7) @(negedge clk);
          chk("R12 hold err", 64'(err_code), (a < 3) ? 0 : 2);
          chk("R12 hold done", 64'(done), 1);
        end
      end
    end

    // R5 masking: x16 with codes whose raw pattern differs only above 16 bits
    stall = 0; acc = 0;
    width_code = 1; interleave = 1; bus_bytes = 2;
    m_code = 32'h37; d_code = 32'h2A61;
    run_probe("R5 masked x16 il1", 1, 0, 0);

    // R7 codes not in table, device answers on first scheme
    m_code = 32'h12; d_code = 32'h34;
    run_probe("R7 unknown codes", 0, 0, 0);

    // R8 window fits first attempt but not the shifted unlock addresses
    width_code = 0; interleave = 1; bus_bytes = 1;
    base_addr = 32'h0; map_size = 32'h1000; acc = 3;
    run_probe("R8 range on retry", 0, 0, 0);
    base_addr = 32'h1000;
    run_probe("R8 base at map end", 0, 0, 0);

    // R10 bad width
    base_addr = 32'h4_0000; map_size = 32'h10_0000;
    width_code = 3;
    @(negedge clk);
    nlog = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R10 done next cycle", 64'(done), 1);
    chk("R10 err bad width", 64'(err_code), 3);
    repeat (5) @(negedge clk);
    chk("R10 no bus ops", 64'(nlog), 0);

    // R12 start during probe ignored, x32 on second scheme
    width_code = 2; interleave = 1; bus_bytes = 4; acc = 1;
    m_code = 32'h91; d_code = 32'h44; stall = 1;
    run_probe("R12 start while busy", 1, 3, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule